// File: doc/BRIEF.md
# Select-Gated SPI Slave

This block is the receive/transmit side of a serial peripheral link. An external master supplies the serial clock, the data line and an active-low select. The block brings all three into the system clock domain and finds clock edges in the oversampled samples. It shifts one byte in and one byte out per transfer and drives MISO only while it takes part in a transfer. The driving logic sees a byte-wide holding register for outgoing data, a received byte and a one-cycle strobe for each byte that completes.

Select gates the clock. A high-to-low edge on select arms the slave and puts the first outgoing bit on MISO. If the master releases select partway through a byte, the byte is not aborted: the slave keeps shifting on the remaining clocks until the eighth bit. After that it ignores every clock until select falls again. Serial clock frequency must be no more than a quarter of the system clock.

Top module: `spi_sel_slave`

## Requirements
- R1: After reset, miso_oe_o and rx_valid_o are 0.
- R2: While the slave is not armed, SCK edges have no effect: no rx_valid_o pulse occurs and miso_oe_o stays 0.
- R3: A high-to-low edge on ss_ni arms the slave. miso_oe_o rises, and miso_o carries bit 7 of the holding register before the first SCK rising edge.
- R4: MOSI is sampled on SCK rising edges, MSB first. After the eighth rising edge, rx_data_o holds the byte, with the first bit sampled in bit 7.
- R5: On each SCK falling edge inside a byte, miso_o advances to the next lower bit of the outgoing byte.
- R6: rx_valid_o is high for exactly one system clock cycle for each completed byte.
- R7: When a byte completes with ss_ni still low, the next outgoing byte is taken from the holding register (written by tx_load_i with tx_data_i), and its bit 7 appears on miso_o.
- R8: Raising ss_ni partway through a byte does not abort it. The byte completes on the remaining SCK edges and is reported with rx_valid_o.
- R9: After a byte completes with ss_ni high, miso_oe_o drops to 0. Further SCK edges are ignored until ss_ni falls again.
- R10: Raising ss_ni between bytes (no bit of a byte received yet) disarms the slave at once, and miso_oe_o drops to 0.
- R11: A fresh high-to-low edge on ss_ni after a disarm re-arms the slave, and transfers resume normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master (asynchronous) |
| mosi_i | input | 1 | Serial data from the master (asynchronous) |
| ss_ni | input | 1 | Active-low select from the master (asynchronous) |
| tx_data_i | input | 8 | Byte written into the transmit holding register |
| tx_load_i | input | 1 | Write strobe for the holding register |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a completed byte |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | MISO drive enable; when 0 the pad is high impedance |

## Verification
A bit counter that is out of step shows up as a received byte that is rotated or shifted, or as an rx_valid_o strobe in the wrong place. The scoreboard catches this at the first byte boundary. A wrong armed state appears directly on miso_oe_o, or as a strobe after select was released, within the few system cycles of synchronizer delay. A bad transmit reload appears on miso_o before the next rising SCK edge.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = $clog2(DATA_W);
  localparam int unsigned SYNC_STAGES = 2;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/spi_sel_sync.sv
module spi_sel_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[g]}};
      else         chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_sel_edge.sv
module spi_sel_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic ss_s_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic ss_fall_o
);
  logic sck_q, ss_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ss_q  <= 1'b1;
    end else begin
      sck_q <= sck_s_i;
      ss_q  <= ss_s_i;
    end
  end
  assign sck_rise_o = sck_s_i & ~sck_q;
  assign sck_fall_o = ~sck_s_i & sck_q;
  assign ss_fall_o  = ss_q & ~ss_s_i;
endmodule

// File: rtl/spi_sel_core.sv
module spi_sel_core
  import spi_sel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ss_s_i,
  input  logic  mosi_s_i,
  input  logic  sck_rise_i,
  input  logic  sck_fall_i,
  input  logic  ss_fall_i,
  input  byte_t tx_data_i,
  input  logic  tx_load_i,
  output byte_t rx_data_o,
  output logic  rx_valid_o,
  output logic  miso_o,
  output logic  armed_o
);
  byte_t hold_q, tx_sh, rx_sh;
  logic [CNT_W-1:0] cnt;
  logic armed;
  logic last_bit;

  assign last_bit = sck_rise_i && armed && (cnt == CNT_W'(DATA_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= '0;
    else if (tx_load_i) hold_q <= tx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed      <= 1'b0;
      cnt        <= '0;
      tx_sh      <= '0;
      rx_sh      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (armed && sck_rise_i) begin
        rx_sh <= {rx_sh[DATA_W-2:0], mosi_s_i};
        if (last_bit) begin
          rx_data_o  <= {rx_sh[DATA_W-2:0], mosi_s_i};
          rx_valid_o <= 1'b1;
          cnt        <= '0;
          tx_sh      <= hold_q;
          armed      <= ~ss_s_i;  // released mid-byte: finish then go quiet
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (armed && sck_fall_i && cnt != '0) begin
        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      end else if (!armed && ss_fall_i) begin
        armed <= 1'b1;
        cnt   <= '0;
        tx_sh <= hold_q;
      end else if (armed && ss_s_i && cnt == '0) begin
        armed <= 1'b0;
      end
    end
  end

  assign miso_o  = tx_sh[DATA_W-1] & armed;
  assign armed_o = armed;

  a_r6_valid_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  a_r3_arm_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed) |-> !ss_s_i);
  a_r2_valid_only_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(armed));
  a_r8_no_abort_mid_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && cnt != '0 && !sck_rise_i) |=> armed);
  a_r7_reload_from_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> tx_sh == $past(hold_q));
endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       ss_ni,
  input  logic [7:0] tx_data_i,
  input  logic       tx_load_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       miso_o,
  output logic       miso_oe_o
);
  logic [2:0] raw, syn;
  logic sck_rise, sck_fall, ss_fall;

  assign raw = {ss_ni, mosi_i, sck_i};

  spi_sel_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn)
  );

  spi_sel_edge u_edge (
    .clk_i, .rst_ni,
    .sck_s_i(syn[0]), .ss_s_i(syn[2]),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .ss_fall_o(ss_fall)
  );

  spi_sel_core u_core (
    .clk_i, .rst_ni,
    .ss_s_i(syn[2]), .mosi_s_i(syn[1]),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .ss_fall_i(ss_fall),
    .tx_data_i, .tx_load_i,
    .rx_data_o, .rx_valid_o, .miso_o, .armed_o(miso_oe_o)
  );

  a_r9_oe_off_idle_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miso_oe_o && syn[2]) |=> !miso_oe_o);
endmodule

// File: tb/sim_spi_sel_slave.sv
module sim_spi_sel_slave;
  logic clk = 0, rst_n = 0;
  logic sck = 0, mosi = 0, ss_n = 1, tx_load = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic rx_valid, miso, miso_oe;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  spi_sel_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .ss_ni(ss_n),
    .tx_data_i(tx_data), .tx_load_i(tx_load), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [7:0] b);
    tx_data = b; tx_load = 1; clks(1); tx_load = 0;
  endtask

  // raise_after: release select after that many rising edges (-1: never)
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_miso,
                      input int raise_after, input bit expect_rx);
    if (expect_rx) exp_q.push_back(mo);
    for (int i = 0; i < 8; i++) begin
      mosi = mo[7-i];
      clks(4);
      if (expect_rx) chk(i == 0 ? "R3/R7 first bit" : "R5 miso shift", {7'b0, miso}, {7'b0, exp_miso[7-i]});
      sck = 1;
      clks(4);
      if (i + 1 == raise_after) ss_n = 1;
      sck = 0;
    end
    clks(4);
  endtask

  // monitor: scoreboard pops expected bytes on each strobe
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2/R9 unexpected rx_valid actual=%h expected=none", rx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          errors++;
          $display("FAIL R4 rx byte actual=%h expected=%h", rx_data, e);
        end
      end
      @(negedge clk);
      chk("R6 strobe width", {7'b0, rx_valid}, 8'h0);
    end
  end

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clks(3);
    chk("R1 oe after reset", {7'b0, miso_oe}, 8'h0);
    chk("R1 valid after reset", {7'b0, rx_valid}, 8'h0);
    rst_n = 1;
    clks(2);
    load(8'hA5);
    // R2: clocks without select are ignored
    xfer(8'hFF, 8'h00, -1, 0);
    chk("R2 oe idle", {7'b0, miso_oe}, 8'h0);
    // R3: arm
    ss_n = 0; clks(6);
    chk("R3 oe armed", {7'b0, miso_oe}, 8'h1);
    chk("R3 miso msb", {7'b0, miso}, 8'h1);
    load(8'h3C);
    xfer(8'h96, 8'hA5, -1, 1);   // R4 R5
    load(8'hC3);
    xfer(8'h5A, 8'h3C, -1, 1);   // R7 back-to-back
    // R10: release between bytes
    ss_n = 1; clks(6);
    chk("R10 disarm between bytes", {7'b0, miso_oe}, 8'h0);
    xfer(8'h11, 8'h00, -1, 0);
    // R11: re-arm
    ss_n = 0; clks(6);
    chk("R11 re-arm", {7'b0, miso_oe}, 8'h1);
    load(8'h81);
    xfer(8'hE7, 8'hC3, 3, 1);    // R8: release after 3 bits
    chk("R9 oe off after finish", {7'b0, miso_oe}, 8'h0);
    xfer(8'h42, 8'h00, -1, 0);   // R9: ignored
    chk("R9 still idle", {7'b0, miso_oe}, 8'h0);
    ss_n = 0; clks(6);
    chk("R11 re-arm again", {7'b0, miso_oe}, 8'h1);
    xfer(8'h00, 8'h81, -1, 1);
    ss_n = 1; clks(8);
    chk("R6 scoreboard drained", 8'(exp_q.size()), 8'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule